// File: doc/BRIEF.md
# Multi-Channel Winograd Convolution Tile Engine

This block produces one 2×2 tile of a 3×3 convolution summed over several input channels, using the nested two-dimensional F(2,3) minimal-filtering method. Each channel is presented as a 4×4 window of input samples, and the matching 3×3 kernel is loaded through its own port. On every accepted channel the engine converts the window into the transform domain, multiplies it position by position with the pre-converted kernel, and adds the 16 products into 16 transform-domain accumulators. When the channel marked last has been absorbed, one inverse conversion turns the 16 sums into the four outputs. The inverse step is therefore paid once per output tile, not once per channel.

Neighbouring output tiles come from input windows that overlap by two rows and two columns. Cutting those windows out of a feature map is left to the surrounding logic. The kernel is converted with its halving factors scaled up by two, so all arithmetic stays in integers. The factor of four this adds is removed exactly after the inverse step.

Channel windows arrive on a valid/ready stream, and results leave on a second valid/ready stream. A window transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers on a rising edge where `out_valid` and `out_ready` are both high. The kernel port is a plain strobe and has no handshake.

Top module: `wino_tile_engine`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and `in_ready` is high.
- R2: Element (row i, column j) of a window sits at bits `[(4i+j)·DW +: DW]` of `in_tile`, and kernel tap (p,q) sits at `[(3p+q)·DW +: DW]` of `flt_taps`, both two's complement. Output (i,j) sits at `[(2i+j)·OW +: OW]` of `out_y`. It equals the sum over the accepted channels of Σp Σq tap(p,q)·window(i+p, j+q), exactly.
- R3: A window accepted with `in_first` high starts a new sum. Everything accumulated before it is discarded.
- R4: For up to CMAX channels, with every sample and tap anywhere in the signed DW-bit range (including the most negative value), the result does not overflow.
- R5: After the edge that accepts a window with `in_last` high, `out_valid` rises on the following edge. `out_valid` never rises at any other time.
- R6: `in_ready` is low for the one cycle after a last window is accepted. It is also low whenever `out_valid` is high and `out_ready` is low. A window presented while `in_ready` is low is not taken and does not change any result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_y` stays unchanged.
- R8: A kernel on `flt_taps` is captured on an edge where `flt_load` is high. A window accepted on that same edge still uses the previously held kernel. The held kernel stays in use for every later window until it is reloaded.
- R9: A window with both `in_first` and `in_last` high gives the single-channel result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flt_load | input | 1 | Capture strobe for the kernel on `flt_taps` |
| flt_taps | input | 9·DW | 3×3 kernel, signed taps |
| in_valid | input | 1 | Channel window present |
| in_ready | output | 1 | Engine accepts a channel window |
| in_first | input | 1 | Window is the first channel of a tile |
| in_last | input | 1 | Window is the last channel of a tile |
| in_tile | input | 16·DW | 4×4 input window, signed samples |
| out_valid | output | 1 | Result tile present |
| out_ready | input | 1 | Downstream takes the result |
| out_y | output | 4·OW | 2×2 result, OW = 2·DW+8+ceil(log2 CMAX) |

## Verification
The bench aims at four weak points. At the full channel count it drives the most negative value into both kernel and window: accumulators that are too narrow would wrap, and an inexact removal of the ×4 scaling would show as an off-by-one error. It restarts a tile with `in_first` in the middle of a sum, where a design that fails to clear would carry stale channels into the result. It also loads a new kernel on the same edge as a window, where a design that captures too early would use the wrong taps. Finally, random back-pressure holds the result while new windows wait at the input: a design that takes a window while stalled would count a channel twice, and one that lets the result change while stalled would lose a tile.

// File: rtl/wino_pkg.sv
package wino_pkg;
  localparam int TILE_N = 4;
  localparam int KERN_N = 3;
  localparam int OUT_N  = 2;
  localparam int TILE_ELEMS = TILE_N * TILE_N;
  localparam int KERN_ELEMS = KERN_N * KERN_N;
  localparam int OUT_ELEMS  = OUT_N * OUT_N;
  // kernel transform carries one extra bit per halving, two halvings total
  localparam int KERN_SCALE_SHIFT = 2;
endpackage

// File: rtl/wino_in_xform.sv
module wino_in_xform
  import wino_pkg::*;
#(
  parameter int DW = 8,
  localparam int VW = DW + 2
) (
  input  logic [TILE_ELEMS*DW-1:0] tile,
  output logic [TILE_ELEMS*VW-1:0] v_flat
);
  logic signed [VW-1:0] d [TILE_ELEMS];
  logic signed [VW-1:0] w [TILE_ELEMS];
  logic signed [VW-1:0] v [TILE_ELEMS];

  always_comb begin
    for (int k = 0; k < TILE_ELEMS; k++) begin
      d[k] = VW'($signed(tile[k*DW +: DW]));
    end
    // left multiply: rows combined column by column
    for (int j = 0; j < TILE_N; j++) begin
      w[0*TILE_N+j] = d[0*TILE_N+j] - d[2*TILE_N+j];
      w[1*TILE_N+j] = d[1*TILE_N+j] + d[2*TILE_N+j];
      w[2*TILE_N+j] = d[2*TILE_N+j] - d[1*TILE_N+j];
      w[3*TILE_N+j] = d[1*TILE_N+j] - d[3*TILE_N+j];
    end
    // right multiply: columns combined row by row
    for (int i = 0; i < TILE_N; i++) begin
      v[i*TILE_N+0] = w[i*TILE_N+0] - w[i*TILE_N+2];
      v[i*TILE_N+1] = w[i*TILE_N+1] + w[i*TILE_N+2];
      v[i*TILE_N+2] = w[i*TILE_N+2] - w[i*TILE_N+1];
      v[i*TILE_N+3] = w[i*TILE_N+1] - w[i*TILE_N+3];
    end
  end

  for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_pack
    assign v_flat[k*VW +: VW] = v[k];
  end
endmodule

// File: rtl/wino_kern_xform.sv
module wino_kern_xform
  import wino_pkg::*;
#(
  parameter int DW = 8,
  localparam int UW = DW + 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [KERN_ELEMS*DW-1:0] taps,
  output logic [TILE_ELEMS*UW-1:0] u_flat
);
  logic signed [UW-1:0] g [KERN_ELEMS];
  logic signed [UW-1:0] q [TILE_N*KERN_N];
  logic signed [UW-1:0] u [TILE_ELEMS];
  logic [TILE_ELEMS*UW-1:0] u_next;

  // doubled transform matrix: rows {2,0,0} {1,1,1} {1,-1,1} {0,0,2}
  always_comb begin
    for (int k = 0; k < KERN_ELEMS; k++) begin
      g[k] = UW'($signed(taps[k*DW +: DW]));
    end
    for (int j = 0; j < KERN_N; j++) begin
      q[0*KERN_N+j] = g[0*KERN_N+j] + g[0*KERN_N+j];
      q[1*KERN_N+j] = g[0*KERN_N+j] + g[1*KERN_N+j] + g[2*KERN_N+j];
      q[2*KERN_N+j] = g[0*KERN_N+j] - g[1*KERN_N+j] + g[2*KERN_N+j];
      q[3*KERN_N+j] = g[2*KERN_N+j] + g[2*KERN_N+j];
    end
    for (int i = 0; i < TILE_N; i++) begin
      u[i*TILE_N+0] = q[i*KERN_N+0] + q[i*KERN_N+0];
      u[i*TILE_N+1] = q[i*KERN_N+0] + q[i*KERN_N+1] + q[i*KERN_N+2];
      u[i*TILE_N+2] = q[i*KERN_N+0] - q[i*KERN_N+1] + q[i*KERN_N+2];
      u[i*TILE_N+3] = q[i*KERN_N+2] + q[i*KERN_N+2];
    end
  end

  for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_pack
    assign u_next[k*UW +: UW] = u[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_flat <= '0;
    end else if (load) begin
      u_flat <= u_next;
    end
  end
endmodule

// File: rtl/wino_mac_array.sv
module wino_mac_array
  import wino_pkg::*;
#(
  parameter int VW = 10,
  parameter int UW = 12,
  parameter int GB = 4,
  localparam int PW = VW + UW,
  localparam int AW = PW + GB
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic                     first,
  input  logic [TILE_ELEMS*VW-1:0] v_flat,
  input  logic [TILE_ELEMS*UW-1:0] u_flat,
  output logic [TILE_ELEMS*AW-1:0] acc_flat
);
  for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_lane
    logic signed [VW-1:0] vk;
    logic signed [UW-1:0] uk;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] base;

    assign vk   = $signed(v_flat[k*VW +: VW]);
    assign uk   = $signed(u_flat[k*UW +: UW]);
    assign prod = PW'(vk) * PW'(uk);
    assign base = first ? '0 : acc_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= '0;
      end else if (fire) begin
        acc_q <= base + AW'(prod);
      end
    end

    assign acc_flat[k*AW +: AW] = acc_q;
  end
endmodule

// File: rtl/wino_out_xform.sv
module wino_out_xform
  import wino_pkg::*;
#(
  parameter int AW = 26,
  localparam int IW = AW + 4,
  localparam int OW = IW - KERN_SCALE_SHIFT
) (
  input  logic [TILE_ELEMS*AW-1:0] acc_flat,
  output logic [OUT_ELEMS*OW-1:0]  y_flat
);
  logic signed [IW-1:0] m [TILE_ELEMS];
  logic signed [IW-1:0] p [OUT_N*TILE_N];
  logic signed [IW-1:0] y [OUT_ELEMS];

  always_comb begin
    for (int k = 0; k < TILE_ELEMS; k++) begin
      m[k] = IW'($signed(acc_flat[k*AW +: AW]));
    end
    for (int j = 0; j < TILE_N; j++) begin
      p[0*TILE_N+j] = m[0*TILE_N+j] + m[1*TILE_N+j] + m[2*TILE_N+j];
      p[1*TILE_N+j] = m[1*TILE_N+j] - m[2*TILE_N+j] - m[3*TILE_N+j];
    end
    for (int i = 0; i < OUT_N; i++) begin
      y[i*OUT_N+0] = p[i*TILE_N+0] + p[i*TILE_N+1] + p[i*TILE_N+2];
      y[i*OUT_N+1] = p[i*TILE_N+1] - p[i*TILE_N+2] - p[i*TILE_N+3];
    end
  end

  // exact division by the kernel scaling: the true sum is an integer
  for (genvar k = 0; k < OUT_ELEMS; k++) begin : g_pack
    assign y_flat[k*OW +: OW] = y[k][IW-1:KERN_SCALE_SHIFT];
  end
endmodule

// File: rtl/wino_tile_engine.sv
module wino_tile_engine
  import wino_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CMAX = 16,
  localparam int VW = DW + 2,
  localparam int UW = DW + 4,
  localparam int GB = $clog2(CMAX),
  localparam int AW = VW + UW + GB,
  localparam int OW = AW + 4 - KERN_SCALE_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flt_load,
  input  logic [KERN_ELEMS*DW-1:0] flt_taps,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic [TILE_ELEMS*DW-1:0] in_tile,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [OUT_ELEMS*OW-1:0]  out_y
);
  logic [TILE_ELEMS*VW-1:0] v_flat;
  logic [TILE_ELEMS*UW-1:0] u_flat;
  logic [TILE_ELEMS*AW-1:0] acc_flat;
  logic [OUT_ELEMS*OW-1:0]  y_new;
  logic fire;
  logic drain_q;
  logic out_valid_q;
  logic [OUT_ELEMS*OW-1:0] out_y_q;

  assign in_ready = !drain_q && (!out_valid_q || out_ready);
  assign fire     = in_valid && in_ready;

  wino_kern_xform #(.DW(DW)) i_kern (
    .clk(clk), .rst(rst), .load(flt_load), .taps(flt_taps), .u_flat(u_flat)
  );

  wino_in_xform #(.DW(DW)) i_in (
    .tile(in_tile), .v_flat(v_flat)
  );

  wino_mac_array #(.VW(VW), .UW(UW), .GB(GB)) i_mac (
    .clk(clk), .rst(rst), .fire(fire), .first(in_first),
    .v_flat(v_flat), .u_flat(u_flat), .acc_flat(acc_flat)
  );

  wino_out_xform #(.AW(AW)) i_out (
    .acc_flat(acc_flat), .y_flat(y_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q     <= 1'b0;
      out_valid_q <= 1'b0;
      out_y_q     <= '0;
    end else begin
      drain_q <= fire && in_last;
      if (drain_q) begin
        out_valid_q <= 1'b1;
        out_y_q     <= y_new;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_y     = out_y_q;
endmodule

// File: rtl/wino_tile_engine_chk.sv
module wino_tile_engine_chk #(
  parameter int YW = 112
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [YW-1:0] out_y
);
  AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready); // R6

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> ##1 out_valid); // R5

  AST_VALID_ONLY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(!in_ready)); // R5

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y))); // R7

  AST_BACKPRESSURE_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R6
endmodule

bind wino_tile_engine wino_tile_engine_chk #(.YW(4*OW)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_y(out_y)
);

// File: tb/test_wino_tile_engine.sv
`timescale 1ns/1ps
module test_wino_tile_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int CMAX = 16;
  localparam int OW   = 2*DW + 8 + $clog2(CMAX);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_load = 1'b0;
  logic [9*DW-1:0] flt_taps = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_first = 1'b0;
  logic in_last = 1'b0;
  logic [16*DW-1:0] in_tile = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4*OW-1:0] out_y;

  int checks = 0;
  int fails = 0;
  bit run_cmp = 1'b0;
  bit bp_mode = 1'b0;
  string cur_req = "R2";

  int cur_g [9];
  int cur_d [16];

  // behavioural model state
  int  m_g [9];
  int  m_acc [4];
  int  m_y [4];
  bit  m_drain, m_ov;

  always #(CLK_PERIOD/2) clk = ~clk;

  wino_tile_engine #(.DW(DW), .CMAX(CMAX)) i_wino_tile_engine (
    .clk(clk), .rst(rst), .flt_load(flt_load), .flt_taps(flt_taps),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
    .in_last(in_last), .in_tile(in_tile), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y)
  );

  function automatic int samp(input logic [16*DW-1:0] t, input int k);
    logic signed [DW-1:0] x;
    x = t[k*DW +: DW];
    return int'(x);
  endfunction

  function automatic int tap(input logic [9*DW-1:0] t, input int k);
    logic signed [DW-1:0] x;
    x = t[k*DW +: DW];
    return int'(x);
  endfunction

  // model: direct 3x3 correlation per channel, summed
  always @(posedge clk) begin
    automatic bit mr = !m_drain && (!m_ov || out_ready);
    automatic int part [4];
    if (rst) begin
      m_drain <= 1'b0;
      m_ov    <= 1'b0;
      for (int k = 0; k < 4; k++) begin m_acc[k] <= 0; m_y[k] <= 0; end
      for (int k = 0; k < 9; k++) m_g[k] <= 0;
    end else begin
      if (in_valid && mr) begin
        for (int i = 0; i < 2; i++)
          for (int j = 0; j < 2; j++) begin
            part[i*2+j] = 0;
            for (int p = 0; p < 3; p++)
              for (int q = 0; q < 3; q++)
                part[i*2+j] += m_g[p*3+q] * samp(in_tile, (i+p)*4 + (j+q));
          end
        for (int k = 0; k < 4; k++)
          m_acc[k] <= in_first ? part[k] : m_acc[k] + part[k];
      end
      if (flt_load)
        for (int k = 0; k < 9; k++) m_g[k] <= tap(flt_taps, k);
      m_drain <= in_valid && mr && in_last;
      if (m_drain) begin
        m_ov <= 1'b1;
        for (int k = 0; k < 4; k++) m_y[k] <= m_acc[k];
      end else if (out_ready) begin
        m_ov <= 1'b0;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      automatic bit er = !m_drain && (!m_ov || out_ready);
      checks++;
      if (in_ready !== er) begin
        fails++;
        $display("FAIL R6 in_ready actual=%b expected=%b t=%0t", in_ready, er, $time);
      end
      checks++;
      if (out_valid !== m_ov) begin
        fails++;
        $display("FAIL R5 out_valid actual=%b expected=%b t=%0t", out_valid, m_ov, $time);
      end
      if (m_ov) begin
        for (int k = 0; k < 4; k++) begin
          automatic logic signed [OW-1:0] a = out_y[k*OW +: OW];
          checks++;
          if (int'(a) != m_y[k]) begin
            fails++;
            $display("FAIL %s out_y[%0d] actual=%0d expected=%0d t=%0t",
                     cur_req, k, int'(a), m_y[k], $time);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (bp_mode) out_ready = ($urandom % 3) != 0;
  end

  task automatic pack_flt();
    for (int k = 0; k < 9; k++) flt_taps[k*DW +: DW] = cur_g[k][DW-1:0];
  endtask

  task automatic pack_tile();
    for (int k = 0; k < 16; k++) in_tile[k*DW +: DW] = cur_d[k][DW-1:0];
  endtask

  task automatic load_flt();
    @(negedge clk); #1;
    pack_flt();
    flt_load = 1'b1;
    @(posedge clk); #1;
    flt_load = 1'b0;
  endtask

  task automatic send_tile(input bit first, input bit last);
    @(negedge clk); #1;
    pack_tile();
    in_first = first; in_last = last; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic rand_fill();
    for (int k = 0; k < 9; k++)  cur_g[k] = $urandom_range(255) - 128;
    for (int k = 0; k < 16; k++) cur_d[k] = $urandom_range(255) - 128;
  endtask

  task automatic rand_tile(input int nch);
    for (int c = 0; c < nch; c++) begin
      rand_fill();
      load_flt();
      send_tile(c == 0, c == nch - 1);
    end
  endtask

  task automatic settle();
    bp_mode = 1'b0;
    @(negedge clk); #1; out_ready = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset actual=valid%b/ready%b expected=valid0/ready1", out_valid, in_ready);
    end
    run_cmp = 1'b1;

    // R2: random multi-channel tiles
    cur_req = "R2";
    for (int n = 0; n < 4; n++) rand_tile(3 + n);
    settle();

    // R9: single-channel tile
    cur_req = "R9";
    rand_tile(1);
    settle();

    // R4: most negative everywhere, full channel count
    cur_req = "R4";
    for (int c = 0; c < CMAX; c++) begin
      foreach (cur_g[k]) cur_g[k] = -128;
      foreach (cur_d[k]) cur_d[k] = -128;
      if (c == 0) load_flt();
      send_tile(c == 0, c == CMAX - 1);
    end
    settle();
    for (int c = 0; c < CMAX; c++) begin
      foreach (cur_g[k]) cur_g[k] = -128;
      foreach (cur_d[k]) cur_d[k] = ((k + c) % 2 == 0) ? 127 : -128;
      load_flt();
      send_tile(c == 0, c == CMAX - 1);
    end
    settle();

    // R3: restart with in_first mid-sum
    cur_req = "R3";
    rand_tile(2);
    rand_fill(); load_flt(); send_tile(1'b1, 1'b0);
    rand_fill(); load_flt(); send_tile(1'b0, 1'b0);
    rand_fill(); load_flt(); send_tile(1'b1, 1'b0);
    rand_fill(); load_flt(); send_tile(1'b0, 1'b1);
    settle();

    // R8: kernel reload on the same edge as a window
    cur_req = "R8";
    rand_fill(); load_flt(); send_tile(1'b1, 1'b0);
    @(negedge clk); #1;
    for (int k = 0; k < 16; k++) cur_d[k] = $urandom_range(255) - 128;
    pack_tile();
    for (int k = 0; k < 9; k++) cur_g[k] = $urandom_range(255) - 128;
    pack_flt();
    in_first = 1'b0; in_last = 1'b0; in_valid = 1'b1; flt_load = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; flt_load = 1'b0;
    for (int k = 0; k < 16; k++) cur_d[k] = $urandom_range(255) - 128;
    send_tile(1'b0, 1'b1);
    settle();

    // R6 and R7: result held under back-pressure, window waiting
    cur_req = "R7";
    rand_tile(2);
    @(negedge clk); #1; out_ready = 1'b0;
    rand_fill(); load_flt();
    fork
      send_tile(1'b1, 1'b1);
      begin repeat (6) @(negedge clk); #1; out_ready = 1'b1; end
    join
    settle();

    // R6: random back-pressure over many tiles
    cur_req = "R6";
    bp_mode = 1'b1;
    for (int n = 0; n < 30; n++) rand_tile(1 + ($urandom % CMAX));
    settle();

    run_cmp = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule